// File: doc/BRIEF.md
# Keep-Alive Current Controller

This block decides when a powered device drops into a low-current keep-alive mode, and while it stays there it drives the pulsed keep-alive current that stops the power source from disconnecting the port. A digital comparator reports whether port current sits below a falling threshold or above a rising threshold. The block samples that comparator on a slow sample tick, and only while the isolation switch is fully on. It enters the mode after a full window of consecutive low samples. It then ignores the comparator for one full keep-alive period, and it leaves the mode on the first sample that shows high current.

While the mode is active, the block drives two outputs. The first is a keep-alive current enable with a fixed period and a selectable on-time. The second is an indicator-LED pulse enable at a quarter duty. A separate detector watches the first classification event. If the class voltage is still present after a long interval, the block truncates the classification current and unlocks the lower duty settings. Otherwise the keep-alive duty stays at its 25% default. The mode flag is given to the sleep logic, so that sleep stays blocked while keep-alive is running.

All inputs are plain level or strobe controls and all outputs are plain levels. No data stream passes through the block, so it has no back-pressure.

Top module: `mps_keepalive_ctrl`

## Requirements
- R1: During reset and on the first cycle after reset, all four outputs are low.
- R2: The comparator is sampled only on sample ticks, one every SAMPLE_CYC clocks. While `sw_full_on` is low, `cmp_below` has no effect and `mps_active` stays low.
- R3: `mps_active` rises after WIN_SAMPLES consecutive ticks with `cmp_below` high. A tick with `cmp_below` low restarts the count.
- R4: After entry, the comparator is ignored for PERIOD_TICKS ticks. `cmp_above` in that interval does not end the mode.
- R5: After the lockout, the first tick with `cmp_above` high clears `mps_active` on the next cycle.
- R6: While active, `ka_en` repeats every PERIOD_TICKS ticks. It is high from the entry cycle for the on-time, and it is never high outside the mode.
- R7: Without a long first event, the on-time is PERIOD_TICKS/4 for every `duty_sel` value.
- R8: If `class_v_ok` is still high LONG_TICKS ticks after a `class_evt_stb` pulse taken while `class_v_ok` was high, `class_trunc` rises and stays high until `class_v_ok` falls. The low-duty selection then stays enabled until reset.
- R9: If `class_v_ok` falls before that interval ends, `class_trunc` stays low and the duty stays at the default.
- R10: With the low-duty selection enabled, `duty_sel` sets the on-time as a fraction of PERIOD_TICKS, rounded down: 0 gives 1/4, 1 gives 15/100, 2 gives 10/100 and 3 gives 5/100.
- R11: While active, `led_en` repeats every LED_TICKS ticks with an on-time of LED_TICKS/4 ticks.
- R12: A low `sw_full_on` ends the mode on the next cycle and clears the low-sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_full_on | input | 1 | Isolation switch fully on |
| cmp_below | input | 1 | Port current below falling threshold |
| cmp_above | input | 1 | Port current above rising threshold |
| class_evt_stb | input | 1 | One-cycle strobe at start of first class event |
| class_v_ok | input | 1 | Class voltage present |
| duty_sel | input | 2 | Keep-alive duty code |
| ka_en | output | 1 | Keep-alive current enable |
| mps_active | output | 1 | Keep-alive mode active, blocks sleep |
| class_trunc | output | 1 | Truncate classification current |
| led_en | output | 1 | Indicator LED pulse enable |

## Verification
The bench builds the block with SAMPLE_CYC=4, WIN_SAMPLES=10, PERIOD_TICKS=40, LONG_TICKS=20 and LED_TICKS=8. With these values the entry window, the full lockout, the long-event timeout and many keep-alive and LED periods all fit in a few thousand cycles. PERIOD_TICKS=40 gives whole-tick on-times for every duty code (10, 6, 4 and 2 ticks), so each code leads to a distinct measured high time. The low sample divider also puts tick phase against input changes in every relation that random segments can produce.

// File: rtl/mps_pkg.sv
package mps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOCK  = 2'd1,
    ST_WATCH = 2'd2
  } mps_state_e;

  // On-time in ticks for a given duty code; default quarter duty unless unlocked
  function automatic int mps_on_ticks(input logic [1:0] code, input logic unlocked,
                                      input int period);
    int r;
    r = period / 4;
    if (unlocked) begin
      case (code)
        2'd1:    r = (period * 15) / 100;
        2'd2:    r = (period * 10) / 100;
        2'd3:    r = (period * 5) / 100;
        default: r = period / 4;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/mps_tick_gen.sv
module mps_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/mps_longevt_det.sv
module mps_longevt_det #(
  parameter int LONG_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic evt_stb,
  input  logic volt_ok,
  output logic trunc,
  output logic unlocked
);
  localparam int CW = (LONG_TICKS > 1) ? $clog2(LONG_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(LONG_TICKS - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic          trunc_q, unl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      trunc_q <= 1'b0;
      unl_q   <= 1'b0;
    end else begin
      if (trunc_q && !volt_ok) trunc_q <= 1'b0;
      if (evt_stb && volt_ok && !unl_q) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        if (!volt_ok) begin
          run_q <= 1'b0;
        end else if (tick) begin
          if (cnt_q == LAST) begin
            run_q   <= 1'b0;
            trunc_q <= 1'b1;
            unl_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign trunc    = trunc_q;
  assign unlocked = unl_q;
endmodule

// File: rtl/mps_mode_fsm.sv
module mps_mode_fsm
  import mps_pkg::*;
#(
  parameter int WIN_SAMPLES  = 10,
  parameter int PERIOD_TICKS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sw_on,
  input  logic below,
  input  logic above,
  output logic active
);
  localparam int WW = (WIN_SAMPLES > 1) ? $clog2(WIN_SAMPLES) : 1;
  localparam int LW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [WW-1:0] WLAST = WW'(WIN_SAMPLES - 1);
  localparam logic [LW-1:0] LLAST = LW'(PERIOD_TICKS - 1);

  mps_state_e    st_q;
  logic [WW-1:0] win_q;
  logic [LW-1:0] lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !sw_on) begin
      st_q   <= ST_IDLE;
      win_q  <= '0;
      lock_q <= '0;
    end else if (tick) begin
      case (st_q)
        ST_IDLE: begin
          if (!below) begin
            win_q <= '0;
          end else if (win_q == WLAST) begin
            win_q  <= '0;
            lock_q <= '0;
            st_q   <= ST_LOCK;
          end else begin
            win_q <= win_q + 1'b1;
          end
        end
        ST_LOCK: begin
          if (lock_q == LLAST) begin
            lock_q <= '0;
            st_q   <= ST_WATCH;
          end else begin
            lock_q <= lock_q + 1'b1;
          end
        end
        ST_WATCH: if (above) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign active = (st_q != ST_IDLE);
endmodule

// File: rtl/mps_pulse_gen.sv
module mps_pulse_gen #(
  parameter int PERIOD = 40,
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1,
  localparam int OW = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [OW-1:0] on_len,
  output logic          pulse
);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) ph_q <= '0;
    else if (tick) ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
  end

  assign pulse = en && ({1'b0, ph_q} < {{(OW - PW){1'b0}}, on_len[OW-1:0]} || (OW == PW && ph_q < on_len[PW-1:0]));
endmodule

// File: rtl/mps_keepalive_ctrl.sv
module mps_keepalive_ctrl
  import mps_pkg::*;
#(
  parameter int SAMPLE_CYC   = 4000,
  parameter int WIN_SAMPLES  = 10,
  parameter int PERIOD_TICKS = 10500,
  parameter int LONG_TICKS   = 2562,
  parameter int LED_TICKS    = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_full_on,
  input  logic       cmp_below,
  input  logic       cmp_above,
  input  logic       class_evt_stb,
  input  logic       class_v_ok,
  input  logic [1:0] duty_sel,
  output logic       ka_en,
  output logic       mps_active,
  output logic       class_trunc,
  output logic       led_en
);
  localparam int KOW = $clog2(PERIOD_TICKS + 1);
  localparam int LOW = $clog2(LED_TICKS + 1);
  localparam logic [LOW-1:0] LED_ON = LOW'(LED_TICKS / 4);

  logic            tick;
  logic            ac_en;
  logic [KOW-1:0]  ka_on;

  mps_tick_gen #(.DIV(SAMPLE_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  mps_longevt_det #(.LONG_TICKS(LONG_TICKS)) u_long (
    .clk(clk), .rst_n(rst_n), .tick(tick), .evt_stb(class_evt_stb),
    .volt_ok(class_v_ok), .trunc(class_trunc), .unlocked(ac_en)
  );

  mps_mode_fsm #(.WIN_SAMPLES(WIN_SAMPLES), .PERIOD_TICKS(PERIOD_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sw_on(sw_full_on),
    .below(cmp_below), .above(cmp_above), .active(mps_active)
  );

  always_comb ka_on = KOW'(mps_on_ticks(duty_sel, ac_en, PERIOD_TICKS));

  mps_pulse_gen #(.PERIOD(PERIOD_TICKS)) u_ka (
    .clk(clk), .rst_n(rst_n), .en(mps_active), .tick(tick),
    .on_len(ka_on), .pulse(ka_en)
  );

  mps_pulse_gen #(.PERIOD(LED_TICKS)) u_led (
    .clk(clk), .rst_n(rst_n), .en(mps_active), .tick(tick),
    .on_len(LED_ON), .pulse(led_en)
  );
endmodule

// File: rtl/mps_keepalive_sva.sv
module mps_keepalive_sva (
  input logic clk,
  input logic rst_n,
  input logic sw_full_on,
  input logic cmp_above,
  input logic class_v_ok,
  input logic ka_en,
  input logic mps_active,
  input logic class_trunc,
  input logic led_en,
  input logic ac_en
);
  p_ka_in_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ka_en |-> mps_active);

  p_start_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mps_active) |-> ka_en);

  p_led_in_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    led_en |-> mps_active);

  p_sw_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_full_on |=> !mps_active);

  p_exit_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mps_active) |-> $past(cmp_above || !sw_full_on));

  p_trunc_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !class_v_ok |=> !class_trunc);

  p_trunc_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(class_trunc) |-> ac_en);

  p_unlock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ac_en) |-> 1'b0);
endmodule

bind mps_keepalive_ctrl mps_keepalive_sva u_sva (
  .clk(clk), .rst_n(rst_n), .sw_full_on(sw_full_on), .cmp_above(cmp_above),
  .class_v_ok(class_v_ok), .ka_en(ka_en), .mps_active(mps_active),
  .class_trunc(class_trunc), .led_en(led_en), .ac_en(ac_en)
);

// File: tb/sim_mps_keepalive_ctrl.sv
module sim_mps_keepalive_ctrl;
  localparam int DIV = 4, WIN = 10, P = 40, LG = 20, L = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_full_on = 1'b0, cmp_below = 1'b0, cmp_above = 1'b0;
  logic class_evt_stb = 1'b0, class_v_ok = 1'b0;
  logic [1:0] duty_sel = 2'd0;
  logic ka_en, mps_active, class_trunc, led_en;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mps_keepalive_ctrl #(.SAMPLE_CYC(DIV), .WIN_SAMPLES(WIN), .PERIOD_TICKS(P),
                       .LONG_TICKS(LG), .LED_TICKS(L)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_full_on(sw_full_on), .cmp_below(cmp_below),
    .cmp_above(cmp_above), .class_evt_stb(class_evt_stb), .class_v_ok(class_v_ok),
    .duty_sel(duty_sel), .ka_en(ka_en), .mps_active(mps_active),
    .class_trunc(class_trunc), .led_en(led_en)
  );

  function automatic int exp_on(input int code, input int unl);
    if (!unl) return P / 4;
    case (code)
      1: return P * 15 / 100;
      2: return P * 10 / 100;
      3: return P * 5 / 100;
      default: return P / 4;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model from the requirements
  int m_div, m_run, m_cnt, m_tr, m_ac, m_st, m_w, m_l, m_ph, m_lph;
  always @(posedge clk) begin
    int tk, ntr;
    if (!rst_n) begin
      m_div = 0; m_run = 0; m_cnt = 0; m_tr = 0; m_ac = 0;
      m_st = 0; m_w = 0; m_l = 0; m_ph = 0; m_lph = 0;
    end else begin
      tk = (m_div == DIV - 1);
      m_div = tk ? 0 : m_div + 1;
      if (m_st == 0) begin m_ph = 0; m_lph = 0; end
      else if (tk) begin
        m_ph = (m_ph == P - 1) ? 0 : m_ph + 1;
        m_lph = (m_lph == L - 1) ? 0 : m_lph + 1;
      end
      ntr = m_tr;
      if (m_tr && !class_v_ok) ntr = 0;
      if (class_evt_stb && class_v_ok && !m_ac) begin m_run = 1; m_cnt = 0; end
      else if (m_run) begin
        if (!class_v_ok) m_run = 0;
        else if (tk) begin
          if (m_cnt == LG - 1) begin m_run = 0; ntr = 1; m_ac = 1; end
          else m_cnt++;
        end
      end
      m_tr = ntr;
      if (!sw_full_on) begin m_st = 0; m_w = 0; m_l = 0; end
      else if (tk) begin
        if (m_st == 0) begin
          if (!cmp_below) m_w = 0;
          else if (m_w == WIN - 1) begin m_w = 0; m_l = 0; m_st = 1; end
          else m_w++;
        end else if (m_st == 1) begin
          if (m_l == P - 1) begin m_l = 0; m_st = 2; end else m_l++;
        end else if (cmp_above) m_st = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3/R4/R5/R12 mps_active", mps_active, m_st != 0);
      chk("R6/R7/R10 ka_en", ka_en, (m_st != 0) && (m_ph < exp_on(duty_sel, m_ac)));
      chk("R8/R9 class_trunc", class_trunc, m_tr);
      chk("R11 led_en", led_en, (m_st != 0) && (m_lph < L / 4));
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic count_high(input int which, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (which == 0 ? ka_en : led_en) hi++;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int hi, len, r;
    void'($urandom(32'd7413));
    step(5);
    @(negedge clk);
    chk("R1 reset ka_en", ka_en, 0); chk("R1 reset mps_active", mps_active, 0);
    chk("R1 reset class_trunc", class_trunc, 0); chk("R1 reset led_en", led_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset mps_active", mps_active, 0);
    // R2: below ignored with switch off
    step(1); cmp_below = 1;
    step(20 * DIV);
    @(negedge clk); chk("R2 no entry with switch off", mps_active, 0);
    // R3: window broken short of full length
    step(1); sw_full_on = 1;
    step((WIN - 1) * DIV); cmp_below = 0;
    step(2 * DIV);
    @(negedge clk); chk("R3 broken window no entry", mps_active, 0);
    step(1); cmp_below = 1;
    step((WIN + 1) * DIV);
    @(negedge clk); chk("R3 entry after full window", mps_active, 1);
    // R4: above ignored during lockout
    step(1); cmp_below = 0; cmp_above = 1;
    step((P - 4) * DIV);
    @(negedge clk); chk("R4 above ignored in lockout", mps_active, 1);
    step(6 * DIV);
    @(negedge clk); chk("R5 exit after lockout", mps_active, 0);
    // R7: default duty regardless of code
    step(1); cmp_above = 0; cmp_below = 1; duty_sel = 2'd3;
    step((WIN + 2) * DIV); cmp_below = 0;
    count_high(0, P * DIV, hi); chk("R7 default on-time code3", hi, (P / 4) * DIV);
    count_high(1, L * DIV, hi); chk("R11 LED on-time", hi, (L / 4) * DIV);
    // R12: switch drop ends mode
    step(1); sw_full_on = 0;
    step(1);
    @(negedge clk); chk("R12 switch drop", mps_active, 0);
    // R9: short first event
    step(1); sw_full_on = 1; class_v_ok = 1; class_evt_stb = 1;
    step(1); class_evt_stb = 0;
    step((LG - 5) * DIV); class_v_ok = 0;
    step(LG * DIV);
    @(negedge clk); chk("R9 short event no truncate", class_trunc, 0);
    // R8: long first event
    step(1); class_v_ok = 1; class_evt_stb = 1;
    step(1); class_evt_stb = 0;
    step((LG + 2) * DIV);
    @(negedge clk); chk("R8 long event truncates", class_trunc, 1);
    step(1); class_v_ok = 0;
    step(1);
    @(negedge clk); chk("R8 truncate drops with voltage", class_trunc, 0);
    // R10: unlocked duty codes
    for (int c = 0; c < 4; c++) begin
      step(1); duty_sel = 2'(c); cmp_below = 1; sw_full_on = 0;
      step(1); sw_full_on = 1;
      step((WIN + 2) * DIV); cmp_below = 0;
      count_high(0, P * DIV, hi);
      chk($sformatf("R10 on-time code%0d", c), hi, exp_on(c, 1) * DIV);
    end
    // Random segments checked against the model every cycle
    for (int s = 0; s < 160; s++) begin
      step(1);
      r = $urandom_range(0, 9);
      sw_full_on = (r != 0);
      r = $urandom_range(0, 2);
      cmp_below = (r == 0); cmp_above = (r == 2);
      duty_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) class_v_ok = ~class_v_ok;
      len = $urandom_range(1, 300);
      step(len);
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule